// File: doc/BRIEF.md
# Synthesizer Divider and Phase-Frequency Detector

This block is the digital heart of a frequency-synthesis tuning loop. A crystal-rate enable drives a fixed reference divider. A prescaled oscillator enable drives a programmable divider with ratio N. The comparison point is the falling edge of each divided signal. A two-flop phase-frequency detector turns the order of those edges into an advance request (the oscillator is early, so the detector raises `pumpUp`) or a retard request (the reference is early, so it raises `pumpDown`). The request lasts from one edge to the other.

The host supplies N and a few control bits: a pump-off bit, a test-route bit, a current-select bit and an amplifier-disable bit. The block drives the pump request and drive-enable pins, the current-select and amplifier-enable pins, and four general port pins. The test-route bit can place the two divided signals on two of those port pins. A lock qualifier watches the width of each completed comparison. It raises `lockFlag` once enough consecutive comparisons have each stayed narrower than a host-programmed width.

Both inputs are single-cycle enables in the `clk` domain. A divided signal is low during the first half of its count and high during the second half, so it falls exactly when the counter wraps to zero.

Top module: `synth_pfd_core`

## Requirements
- R1: The reference divider falls once every REF_RATIO asserted `refTick` cycles, with the first fall on the REF_RATIO-th tick after reset. Its signal is high while its count (0..REF_RATIO-1) is at least REF_RATIO/2.
- R2: The programmable divider falls once every Ncur asserted `vcoTick` cycles, with its count running 0..Ncur-1. At each fall, Ncur is reloaded from `divN`, so a new N applies from the next divider cycle. After reset, Ncur is N_MIN. The signal is high while the count is at least Ncur/2.
- R3: A `divN` value below N_MIN is loaded as N_MIN.
- R4: A divider fall sets its own request (the programmable divider sets UP, the reference divider sets DOWN) from the following cycle. The request holds until the other divider falls, and it clears in the cycle after that fall.
- R5: When both falls occur in the same cycle, or complete an open request, no request stays active. `pumpUp` and `pumpDown` are never high together.
- R6: `pumpDrive` is high exactly when a request is active and `pumpOff` is 0. When `pumpOff` is 1, `pumpUp`, `pumpDown` and `pumpDrive` are all 0.
- R7: With `testRoute` = 1, `portOut[2]` carries the reference divided signal, `portOut[3]` carries the programmable divided signal, and `portOut[1:0]` follow `portBits[1:0]`. With `testRoute` = 0, `portOut` equals `portBits`.
- R8: `hiCurrentSel` follows `hiCurrent`, and `ampEnable` is the inverse of `ampDisable`.
- R9: Each completed comparison has a width: the number of cycles its request was active, or 0 for coincident falls. `lockFlag` rises after LOCK_CYCLES consecutive completions with width below `lockWindow`. It clears at the first completion whose width is at or above `lockWindow`.
- R10: While `rstN` is low, no request, drive or lock is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | Crystal-rate count enable |
| vcoTick | input | 1 | Prescaled oscillator count enable |
| divN | input | N_W | Programmable divide ratio |
| lockWindow | input | PW_W | Width limit for a good comparison |
| pumpOff | input | 1 | Forces the pump output idle |
| testRoute | input | 1 | Places divided signals on port pins |
| hiCurrent | input | 1 | Pump current select bit |
| ampDisable | input | 1 | Tuning amplifier disable bit |
| portBits | input | 4 | Port pin register bits |
| pumpUp | output | 1 | Advance request |
| pumpDown | output | 1 | Retard request |
| pumpDrive | output | 1 | Pump output enable (0 = high impedance) |
| lockFlag | output | 1 | Loop lock indication |
| hiCurrentSel | output | 1 | Pump current select |
| ampEnable | output | 1 | Tuning amplifier enable |
| portOut | output | 4 | Port pins |

## Verification
A divider count that is off, or a wrong latched ratio, first shows on the routed divided signals in the same cycle as the bad count. One divider cycle later it also shows as a shifted or widened request on `pumpUp` or `pumpDown`. A detector flop that is stuck or cleared late shows up as a request that is one cycle too long, or as both requests high together, right after the second fall. A fault in the lock counter changes `lockFlag` only at a completion. It can therefore go unseen for up to LOCK_CYCLES comparison periods, so the bench holds steady patterns for several full reference periods before it checks lock.

// File: rtl/synth_pfd_pkg.sv
package synth_pfd_pkg;

  // Single-cycle falling-edge strobes from the dividers to the detector
  typedef struct packed {
    logic refFall;
    logic vcoFall;
  } divEdges_t;

endpackage

// File: rtl/synth_div_path.sv
module synth_div_path
  import synth_pfd_pkg::*;
#(
  parameter int REF_RATIO = 512,
  parameter int N_W       = 15,
  parameter int N_MIN     = 256
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           refTick,
  input  logic           vcoTick,
  input  logic [N_W-1:0] divN,
  output divEdges_t      edgeStb,
  output logic           refSig,
  output logic           vcoSig
);

  localparam int REF_W = $clog2(REF_RATIO);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_RATIO - 1);
  localparam logic [REF_W-1:0] REF_HALF = REF_W'(REF_RATIO / 2);
  localparam logic [N_W-1:0]   N_FLOOR  = N_W'(N_MIN);

  logic [REF_W-1:0] refCnt;
  logic [N_W-1:0]   vcoCnt;
  logic [N_W-1:0]   nCur;
  logic [N_W-1:0]   nEff;
  logic             refWrap;
  logic             vcoWrap;

  // Reference divider: fixed ratio, falls on wrap to zero
  assign refWrap = refTick && (refCnt == REF_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (refTick) begin
      refCnt <= refWrap ? '0 : refCnt + 1'b1;
    end
  end

  // Programmable divider: ratio latched at each wrap, floored at N_MIN
  assign nEff    = (divN < N_FLOOR) ? N_FLOOR : divN;
  assign vcoWrap = vcoTick && (vcoCnt == nCur - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vcoCnt <= '0;
      nCur   <= N_FLOOR;
    end else if (vcoWrap) begin
      vcoCnt <= '0;
      nCur   <= nEff;
    end else if (vcoTick) begin
      vcoCnt <= vcoCnt + 1'b1;
    end
  end

  assign refSig = (refCnt >= REF_HALF);
  assign vcoSig = (vcoCnt >= (nCur >> 1));

  assign edgeStb.refFall = refWrap;
  assign edgeStb.vcoFall = vcoWrap;

endmodule

// File: rtl/synth_pfd_ctrl.sv
module synth_pfd_ctrl
  import synth_pfd_pkg::*;
#(
  parameter int PW_W        = 8,
  parameter int LOCK_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  divEdges_t       edgeStb,
  input  logic [PW_W-1:0] lockWindow,
  output logic            upAct,
  output logic            dnAct,
  output logic            pairDone,
  output logic            lockFlag
);

  localparam int GOOD_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(LOCK_CYCLES);

  logic              setUp;
  logic              setDn;
  logic              active;
  logic [PW_W-1:0]   pwCnt;
  logic [PW_W:0]     measured;
  logic              goodCmp;
  logic [GOOD_W-1:0] goodCnt;

  // Each fall sets its flop; seeing both edges clears the pair
  assign setUp    = upAct | edgeStb.vcoFall;
  assign setDn    = dnAct | edgeStb.refFall;
  assign pairDone = setUp & setDn;
  assign active   = upAct | dnAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upAct <= 1'b0;
      dnAct <= 1'b0;
    end else begin
      upAct <= setUp & ~setDn;
      dnAct <= setDn & ~setUp;
    end
  end

  // Width of the request in cycles, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwCnt <= '0;
    end else if (pairDone) begin
      pwCnt <= '0;
    end else if (active && (pwCnt != {PW_W{1'b1}})) begin
      pwCnt <= pwCnt + 1'b1;
    end
  end

  assign measured = {1'b0, pwCnt} + {{PW_W{1'b0}}, active};
  assign goodCmp  = (measured < {1'b0, lockWindow});

  // Consecutive narrow comparisons qualify lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt <= '0;
    end else if (pairDone) begin
      if (!goodCmp) begin
        goodCnt <= '0;
      end else if (goodCnt != GOOD_FULL) begin
        goodCnt <= goodCnt + 1'b1;
      end
    end
  end

  assign lockFlag = (goodCnt == GOOD_FULL);

endmodule

// File: rtl/synth_pfd_core.sv
module synth_pfd_core
  import synth_pfd_pkg::*;
#(
  parameter int REF_RATIO   = 512,
  parameter int N_W         = 15,
  parameter int N_MIN       = 256,
  parameter int PW_W        = 8,
  parameter int LOCK_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refTick,
  input  logic            vcoTick,
  input  logic [N_W-1:0]  divN,
  input  logic [PW_W-1:0] lockWindow,
  input  logic            pumpOff,
  input  logic            testRoute,
  input  logic            hiCurrent,
  input  logic            ampDisable,
  input  logic [3:0]      portBits,
  output logic            pumpUp,
  output logic            pumpDown,
  output logic            pumpDrive,
  output logic            lockFlag,
  output logic            hiCurrentSel,
  output logic            ampEnable,
  output logic [3:0]      portOut
);

  divEdges_t edgeStb;
  logic      refSig;
  logic      vcoSig;
  logic      upAct;
  logic      dnAct;
  logic      pairDone;

  synth_div_path #(
    .REF_RATIO (REF_RATIO),
    .N_W       (N_W),
    .N_MIN     (N_MIN)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .vcoTick (vcoTick),
    .divN    (divN),
    .edgeStb (edgeStb),
    .refSig  (refSig),
    .vcoSig  (vcoSig)
  );

  synth_pfd_ctrl #(
    .PW_W        (PW_W),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .edgeStb    (edgeStb),
    .lockWindow (lockWindow),
    .upAct      (upAct),
    .dnAct      (dnAct),
    .pairDone   (pairDone),
    .lockFlag   (lockFlag)
  );

  assign pumpUp       = upAct & ~pumpOff;
  assign pumpDown     = dnAct & ~pumpOff;
  assign pumpDrive    = (upAct | dnAct) & ~pumpOff;
  assign hiCurrentSel = hiCurrent;
  assign ampEnable    = ~ampDisable;

  // Bit 3 and bit 2 carry the divided signals in test routing
  always_comb begin
    portOut = portBits;
    if (testRoute) begin
      portOut[3] = vcoSig;
      portOut[2] = refSig;
    end
  end

endmodule

// File: rtl/synth_pfd_core_chk.sv
module synth_pfd_core_chk
  import synth_pfd_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input divEdges_t edgeStb,
  input logic      upAct,
  input logic      dnAct,
  input logic      pairDone,
  input logic      lockFlag,
  input logic      pumpUp,
  input logic      pumpDown
);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(upAct && dnAct)) else $error("request flops both set"); // R5

  AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(pumpUp && pumpDown)) else $error("pump pins both high"); // R5

  AST_UP_FROM_VCO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upAct) |-> $past(edgeStb.vcoFall)) else $error("up without vco fall"); // R4

  AST_DN_FROM_REF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnAct) |-> $past(edgeStb.refFall)) else $error("down without ref fall"); // R4

  AST_LOCK_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(pairDone)) else $error("lock rose off a completion"); // R9

  AST_LOCK_FALL_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockFlag) |-> $past(pairDone)) else $error("lock fell off a completion"); // R9

endmodule

bind synth_pfd_core synth_pfd_core_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .edgeStb  (edgeStb),
  .upAct    (upAct),
  .dnAct    (dnAct),
  .pairDone (pairDone),
  .lockFlag (lockFlag),
  .pumpUp   (pumpUp),
  .pumpDown (pumpDown)
);

// File: tb/synth_pfd_core_bench.sv
`timescale 1ns/1ps
module synth_pfd_core_bench;

  localparam int REF_RATIO   = 16;
  localparam int N_W         = 6;
  localparam int N_MIN       = 4;
  localparam int PW_W        = 8;
  localparam int LOCK_CYCLES = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            refTick = 1'b0;
  logic            vcoTick = 1'b0;
  logic [N_W-1:0]  divN = '0;
  logic [PW_W-1:0] lockWindow = '0;
  logic            pumpOff = 1'b0;
  logic            testRoute = 1'b0;
  logic            hiCurrent = 1'b0;
  logic            ampDisable = 1'b0;
  logic [3:0]      portBits = '0;
  logic            pumpUp, pumpDown, pumpDrive, lockFlag, hiCurrentSel, ampEnable;
  logic [3:0]      portOut;

  always #2.5 clk = ~clk;

  synth_pfd_core #(
    .REF_RATIO(REF_RATIO), .N_W(N_W), .N_MIN(N_MIN),
    .PW_W(PW_W), .LOCK_CYCLES(LOCK_CYCLES)
  ) u_synth_pfd_core (
    .clk(clk), .rstN(rstN), .refTick(refTick), .vcoTick(vcoTick),
    .divN(divN), .lockWindow(lockWindow), .pumpOff(pumpOff),
    .testRoute(testRoute), .hiCurrent(hiCurrent), .ampDisable(ampDisable),
    .portBits(portBits), .pumpUp(pumpUp), .pumpDown(pumpDown),
    .pumpDrive(pumpDrive), .lockFlag(lockFlag), .hiCurrentSel(hiCurrentSel),
    .ampEnable(ampEnable), .portOut(portOut)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 0;
  string vcoTag = "R2 vco signal on P7";

  // Requirement-level model state
  int mRefCnt, mVcoCnt, mNCur, mPw, mGood;
  bit mUp, mDn;
  bit sawPulse;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mRefCnt = 0; mVcoCnt = 0; mNCur = N_MIN;
    mPw = 0; mGood = 0; mUp = 0; mDn = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; refTick = 1'b0; vcoTick = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    chk("R10 pumpUp in reset", int'(pumpUp), 0);
    chk("R10 pumpDown in reset", int'(pumpDown), 0);
    chk("R10 pumpDrive in reset", int'(pumpDrive), 0);
    chk("R10 lockFlag in reset", int'(lockFlag), 0);
    rstN = 1'b1;
  endtask

  task automatic compareAll();
    chk("R4 pumpUp", int'(pumpUp), int'(mUp && !pumpOff));
    chk("R4 pumpDown", int'(pumpDown), int'(mDn && !pumpOff));
    chk("R6 pumpDrive", int'(pumpDrive), int'((mUp || mDn) && !pumpOff));
    chk("R5 never both", int'(pumpUp && pumpDown), 0);
    chk("R9 lockFlag", int'(lockFlag), int'(mGood == LOCK_CYCLES));
    chk("R8 hiCurrentSel", int'(hiCurrentSel), int'(hiCurrent));
    chk("R8 ampEnable", int'(ampEnable), int'(!ampDisable));
    if (testRoute) begin
      chk("R1 ref signal on P6", int'(portOut[2]), int'(mRefCnt >= REF_RATIO / 2));
      chk(vcoTag, int'(portOut[3]), int'(mVcoCnt >= mNCur / 2));
      chk("R7 P5..P4 in test", int'(portOut[1:0]), int'(portBits[1:0]));
    end else begin
      chk("R7 ports from register", int'(portOut), int'(portBits));
    end
  endtask

  task automatic step(input bit rT, input bit vT);
    bit rF, vF, sU, sD, done;
    int meas;
    @(negedge clk);
    refTick = rT; vcoTick = vT;
    rF = rT && (mRefCnt == REF_RATIO - 1);
    vF = vT && (mVcoCnt == mNCur - 1);
    if (rT) mRefCnt = rF ? 0 : mRefCnt + 1;
    if (vF) begin
      mVcoCnt = 0;
      mNCur = (int'(divN) < N_MIN) ? N_MIN : int'(divN);
    end else if (vT) begin
      mVcoCnt = mVcoCnt + 1;
    end
    sU = mUp | vF;
    sD = mDn | rF;
    done = sU & sD;
    meas = mPw + int'(mUp | mDn);
    if (done) begin
      mPw = 0;
      if (meas < int'(lockWindow)) begin
        if (mGood < LOCK_CYCLES) mGood = mGood + 1;
      end else begin
        mGood = 0;
      end
    end else if ((mUp | mDn) && mPw < 255) begin
      mPw = mPw + 1;
    end
    mUp = sU & !sD;
    mDn = sD & !sU;
    @(posedge clk);
    #1;
    if (pumpDrive) sawPulse = 1;
    compareAll();
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // Coincident falls: in-phase loop
    divN = 6'd16; lockWindow = 8'd1; testRoute = 1'b1;
    doReset();
    sawPulse = 0;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1);
    chk("R5 in-phase gives no pulse", int'(sawPulse), 0);
    chk("R9 lock with in-phase falls", int'(lockFlag), 1);

    // Steady leading oscillator, lock and unlock, then ratio change
    doReset();
    divN = 6'd16; lockWindow = 8'd20;
    for (int i = 0; i < 120; i++) step(1'b1, 1'b1);
    chk("R9 lock with narrow pulses", int'(lockFlag), 1);
    lockWindow = 8'd5;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
    chk("R9 lock drops on wide pulse", int'(lockFlag), 0);
    divN = 6'd20;
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1);

    // Sweep of ratios with irregular ticks and all control bits
    doReset();
    lockWindow = 8'd8;
    for (int n = 1; n <= 40; n++) begin
      divN       = N_W'(n);
      testRoute  = n[0];
      hiCurrent  = n[1];
      ampDisable = n[2];
      portBits   = 4'(n);
      pumpOff    = (n % 5 == 0);
      vcoTag     = (n < N_MIN) ? "R3 clamped vco on P7" : "R2 vco signal on P7";
      for (int i = 0; i < 64; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5]);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule